// File: doc/BRIEF.md
# Configuration Space Access Router

This block stands between a configuration request port and the storage behind a bridge's configuration space. Each request carries a byte offset, a byte count of 1, 2 or 4, a direction and write data. The block sorts the dword-aligned offset into one of four windows: the standard header, a small read-only subsystem-identity capability, a PCIe capability structure, or the extended space above 0x100. Which windows exist is set at run time by two configuration inputs: a subsystem vendor ID (nonzero turns the identity capability on) and a PCIe mode flag (turns on both the PCIe capability and the extended space).

For windows backed by storage, the block drives a one-hot target select, a region-relative dword index, a byte-lane write mask and lane-aligned write data, and takes back a combinational read dword from each store. The identity capability has no storage: its two dwords are built from the configuration inputs. The block also derives the header's first-capability pointer and links the identity capability to the PCIe capability when both are present.

Every request gets a response one cycle later carrying the read value (lanes already shifted down and masked) and an error flag. Offsets outside any active window read as zero without error, and writes there are dropped.

Top module: `cfg_access_router`

## Requirements
- R1: A request whose aligned offset is below 0x40 selects the header store (tgt_sel bit 0) with dword index equal to the aligned offset divided by 4.
- R2: When cfg_ssvid is nonzero, aligned offsets 0x40 and 0x44 read the identity capability: the dword at 0x40 is {16'h0000, next, 8'h0D} with next = 0x48 in PCIe mode and 0x00 otherwise; the dword at 0x44 is {cfg_ssid, cfg_ssvid}. Writes there never assert tgt_wr_en.
- R3: In PCIe mode, aligned offsets 0x48 to 0x83 select the capability store (tgt_sel bit 1) with index (offset - 0x48)/4, and aligned offsets from 0x100 upward select the extended store (tgt_sel bit 2) with index (offset - 0x100)/4.
- R4: An offset in no active window reads 0 with no error, and a write there leaves tgt_wr_en low.
- R5: hdr_cap_ptr is 0x40 when cfg_ssvid is nonzero, else 0x48 in PCIe mode, else 0x00; a read of the header dword at 0x34 returns this value in its lowest byte, the upper three bytes coming from the header store.
- R6: A read returns the addressed dword shifted right by 8 x (offset mod 4) and masked to 8 bits for a 1-byte access or 16 bits for a 2-byte access; a 4-byte access returns the dword unshifted.
- R7: On a write, tgt_wmask is 0xFFFFFFFF for 4 bytes, 0xFFFF or 0xFF shifted left by 8 x (offset mod 4) for 2 or 1 bytes, and tgt_wdata is req_wdata shifted by the same amount.
- R8: A byte count other than 1, 2 or 4, or a 2-byte access at offset mod 4 = 3, returns rsp_err = 1 with rsp_data = 0 and never asserts tgt_wr_en.
- R9: rsp_valid is high for exactly the cycle after each cycle with req_valid high; a write response carries rsp_data = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_offset | input | OFF_W | Byte offset into configuration space |
| req_size | input | 3 | Byte count (1, 2 or 4 valid) |
| req_wdata | input | 32 | Write data, right-justified |
| cfg_pcie_mode | input | 1 | Enables PCIe capability and extended space |
| cfg_ssvid | input | 16 | Subsystem vendor ID; nonzero enables identity capability |
| cfg_ssid | input | 16 | Subsystem ID |
| hdr_rdata | input | 32 | Dword read from the header store |
| cap_rdata | input | 32 | Dword read from the PCIe capability store |
| ext_rdata | input | 32 | Dword read from the extended store |
| tgt_sel | output | 3 | One-hot store select: bit0 header, bit1 capability, bit2 extended |
| tgt_dw_addr | output | OFF_W-2 | Region-relative dword index |
| tgt_wr_en | output | 1 | Write strobe to the selected store |
| tgt_wmask | output | 32 | Byte-lane write mask |
| tgt_wdata | output | 32 | Lane-aligned write data |
| hdr_cap_ptr | output | 8 | Derived first-capability pointer |
| rsp_valid | output | 1 | Response strobe |
| rsp_data | output | 32 | Read result |
| rsp_err | output | 1 | Bad access size or alignment |

## Verification
The store write and the capability-pointer merge meet on the header dword at 0x34: a write to that dword updates the store at the same edge the block is free to accept the next request, and a read issued in the very next cycle must merge the freshly stored upper bytes with the computed pointer in the lowest byte. The bench provokes this with a back-to-back write and read of 0x34 and judges it against a byte-level model of configuration space, which it also uses to confirm that the pointer byte follows each configuration change rather than the written data.

// File: rtl/cfg_access_router.sv
module cfg_access_router #(
  parameter int OFF_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             req_write,
  input  logic [OFF_W-1:0] req_offset,
  input  logic [2:0]       req_size,
  input  logic [31:0]      req_wdata,
  input  logic             cfg_pcie_mode,
  input  logic [15:0]      cfg_ssvid,
  input  logic [15:0]      cfg_ssid,
  input  logic [31:0]      hdr_rdata,
  input  logic [31:0]      cap_rdata,
  input  logic [31:0]      ext_rdata,
  output logic [2:0]       tgt_sel,
  output logic [OFF_W-3:0] tgt_dw_addr,
  output logic             tgt_wr_en,
  output logic [31:0]      tgt_wmask,
  output logic [31:0]      tgt_wdata,
  output logic [7:0]       hdr_cap_ptr,
  output logic             rsp_valid,
  output logic [31:0]      rsp_data,
  output logic             rsp_err
);

  localparam logic [OFF_W-1:0] IDC_BASE = OFF_W'(12'h040);
  localparam logic [OFF_W-1:0] PCI_BASE = OFF_W'(12'h048);
  localparam logic [OFF_W-1:0] PCI_END  = OFF_W'(12'h084);
  localparam logic [OFF_W-1:0] EXT_BASE = OFF_W'(12'h100);
  localparam logic [OFF_W-1:0] PTR_DW   = OFF_W'(12'h034);

  logic [OFF_W-1:0] aligned, rel;
  logic [1:0]       bo;
  logic [4:0]       sh;
  logic             idc_on, in_hdr, in_idc, in_pci, in_ext, size_ok;
  logic [31:0]      raw, shifted, rd_lanes, idc_word;

  assign aligned = {req_offset[OFF_W-1:2], 2'b00};
  assign bo      = req_offset[1:0];
  assign sh      = {bo, 3'b000};
  assign idc_on  = |cfg_ssvid;

  assign in_hdr = aligned < IDC_BASE;
  assign in_idc = idc_on && aligned >= IDC_BASE && aligned < PCI_BASE;
  assign in_pci = cfg_pcie_mode && aligned >= PCI_BASE && aligned < PCI_END;
  assign in_ext = cfg_pcie_mode && aligned >= EXT_BASE;

  assign size_ok = (req_size == 3'd1) || (req_size == 3'd4) ||
                   (req_size == 3'd2 && bo != 2'd3);

  assign hdr_cap_ptr = idc_on ? 8'h40 : (cfg_pcie_mode ? 8'h48 : 8'h00);
  assign idc_word    = aligned[2] ? {cfg_ssid, cfg_ssvid}
                                  : {16'h0000, (cfg_pcie_mode ? 8'h48 : 8'h00), 8'h0D};

  always_comb begin
    rel = aligned;
    if (in_pci)      rel = aligned - PCI_BASE;
    else if (in_ext) rel = aligned - EXT_BASE;
  end

  assign tgt_sel     = req_valid ? {in_ext, in_pci, in_hdr} : 3'b000;
  assign tgt_dw_addr = rel[OFF_W-1:2];

  always_comb begin
    raw = 32'h0;
    if (in_hdr)      raw = (aligned == PTR_DW) ? {hdr_rdata[31:8], hdr_cap_ptr} : hdr_rdata;
    else if (in_idc) raw = idc_word;
    else if (in_pci) raw = cap_rdata;
    else if (in_ext) raw = ext_rdata;
  end

  assign shifted = raw >> sh;

  always_comb begin
    case (req_size)
      3'd1:    rd_lanes = {24'h0, shifted[7:0]};
      3'd2:    rd_lanes = {16'h0, shifted[15:0]};
      default: rd_lanes = raw;
    endcase
  end

  always_comb begin
    case (req_size)
      3'd4:    tgt_wmask = 32'hFFFF_FFFF;
      3'd2:    tgt_wmask = 32'h0000_FFFF << sh;
      3'd1:    tgt_wmask = 32'h0000_00FF << sh;
      default: tgt_wmask = 32'h0;
    endcase
  end

  assign tgt_wdata = (req_size == 3'd4) ? req_wdata : (req_wdata << sh);
  assign tgt_wr_en = req_valid && req_write && size_ok && (in_hdr || in_pci || in_ext);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_data  <= 32'h0;
    end else begin
      rsp_valid <= req_valid;
      rsp_err   <= req_valid && !size_ok;
      rsp_data  <= (req_valid && !req_write && size_ok) ? rd_lanes : 32'h0;
    end
  end

  AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid); // R9
  AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid); // R9
  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> rsp_data == 32'h0); // R8
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(tgt_sel)); // R3
  AST_WR_HAS_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    tgt_wr_en |-> ($countones(tgt_sel) == 1 && tgt_wmask != 32'h0)); // R4
  AST_BYTE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_err && $past(req_size) == 3'd1) |-> rsp_data[31:8] == 24'h0); // R6
  AST_PTR_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_cap_ptr == 8'h00 || hdr_cap_ptr == 8'h40 || hdr_cap_ptr == 8'h48); // R5

endmodule

// File: tb/cfg_access_router_tb.sv
module cfg_access_router_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        req_valid = 0, req_write = 0;
  logic [11:0] req_offset = 0;
  logic [2:0]  req_size = 0;
  logic [31:0] req_wdata = 0;
  logic        cfg_pcie_mode = 1;
  logic [15:0] cfg_ssvid = 16'h1AB4, cfg_ssid = 16'h7788;
  logic [31:0] hdr_rdata, cap_rdata, ext_rdata;
  logic [2:0]  tgt_sel;
  logic [9:0]  tgt_dw_addr;
  logic        tgt_wr_en;
  logic [31:0] tgt_wmask, tgt_wdata;
  logic [7:0]  hdr_cap_ptr;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_data;

  cfg_access_router #(.OFF_W(12)) u_dut (
    .clk, .rst_n, .req_valid, .req_write, .req_offset, .req_size, .req_wdata,
    .cfg_pcie_mode, .cfg_ssvid, .cfg_ssid, .hdr_rdata, .cap_rdata, .ext_rdata,
    .tgt_sel, .tgt_dw_addr, .tgt_wr_en, .tgt_wmask, .tgt_wdata, .hdr_cap_ptr,
    .rsp_valid, .rsp_data, .rsp_err);

  function automatic logic [31:0] pat(int a);
    return 32'hC3A5_0000 ^ (32'(a) << 16) ^ (32'(a) * 32'h0000_0107);
  endfunction

  logic [31:0] hdr_mem [16];
  logic [31:0] cap_mem [16];
  logic [31:0] ext_mem [1024];
  logic [7:0]  mdl [4096];

  assign hdr_rdata = hdr_mem[tgt_dw_addr[3:0]];
  assign cap_rdata = cap_mem[tgt_dw_addr[3:0]];
  assign ext_rdata = ext_mem[tgt_dw_addr];

  always @(posedge clk)
    if (tgt_wr_en) begin
      if (tgt_sel[0]) hdr_mem[tgt_dw_addr[3:0]] <= (hdr_mem[tgt_dw_addr[3:0]] & ~tgt_wmask) | (tgt_wdata & tgt_wmask);
      if (tgt_sel[1]) cap_mem[tgt_dw_addr[3:0]] <= (cap_mem[tgt_dw_addr[3:0]] & ~tgt_wmask) | (tgt_wdata & tgt_wmask);
      if (tgt_sel[2]) ext_mem[tgt_dw_addr] <= (ext_mem[tgt_dw_addr] & ~tgt_wmask) | (tgt_wdata & tgt_wmask);
    end

  int checks = 0, fails = 0;
  bit done = 0;
  logic [31:0] q_data[$];
  logic        q_err[$];
  string       q_tag[$];

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor / scoreboard
  always @(negedge clk)
    if (rst_n && rsp_valid) begin
      if (q_data.size() == 0) check("R9 unexpected response", 32'h1, 32'h0);
      else begin
        logic [31:0] d; logic e; string t;
        d = q_data.pop_front(); e = q_err.pop_front(); t = q_tag.pop_front();
        check({t, " data"}, rsp_data, d);
        check({t, " err"}, {31'h0, rsp_err}, {31'h0, e});
      end
    end

  function automatic logic [7:0] exp_ptr();
    return (cfg_ssvid != 0) ? 8'h40 : (cfg_pcie_mode ? 8'h48 : 8'h00);
  endfunction

  // 0 none, 1 header, 2 identity, 3 pcie, 4 ext
  function automatic int region(int a);
    if (a < 'h40) return 1;
    if (cfg_ssvid != 0 && a >= 'h40 && a < 'h48) return 2;
    if (cfg_pcie_mode && a >= 'h48 && a < 'h84) return 3;
    if (cfg_pcie_mode && a >= 'h100) return 4;
    return 0;
  endfunction

  task automatic acc(bit w, int off, int sz, logic [31:0] wd, string tag);
    int a, b, r; bit bad; logic [31:0] dw, ed, m;
    a = off & ~3; b = off & 3; r = region(a);
    bad = !(sz == 1 || sz == 4 || (sz == 2 && b != 3));
    dw = 0;
    if (r == 1 || r == 3 || r == 4)
      for (int k = 0; k < 4; k++) dw[8*k +: 8] = mdl[a+k];
    if (r == 1 && a == 'h34) dw[7:0] = exp_ptr();
    if (r == 2) dw = (a == 'h44) ? {cfg_ssid, cfg_ssvid} : {16'h0, (cfg_pcie_mode ? 8'h48 : 8'h00), 8'h0D};
    if (sz == 4) ed = dw;
    else if (sz == 2) ed = (dw >> (8*b)) & 32'hFFFF;
    else ed = (dw >> (8*b)) & 32'hFF;
    if (bad || w) ed = 0;
    m = (sz == 4) ? 32'hFFFF_FFFF : (((sz == 2) ? 32'hFFFF : 32'hFF) << (8*b));
    q_data.push_back(ed); q_err.push_back(bad); q_tag.push_back(tag);
    req_valid = 1; req_write = w; req_offset = 12'(off); req_size = 3'(sz); req_wdata = wd;
    #1;
    if (w) begin
      bit wr; wr = !bad && (r == 1 || r == 3 || r == 4);
      check({tag, " wr_en"}, {31'h0, tgt_wr_en}, {31'h0, wr});
      if (wr) begin
        check({tag, " R7 wmask"}, tgt_wmask, m);
        check({tag, " R7 wdata"}, tgt_wdata & m, (sz == 4 ? wd : wd << (8*b)) & m);
        for (int k = 0; k < 4; k++)
          if (m[8*k]) mdl[a+k] = 8'((wd << (sz == 4 ? 0 : 8*b)) >> (8*k));
      end
    end else if (!bad && r != 2) begin
      logic [2:0] es; es = (r == 1) ? 3'b001 : (r == 3) ? 3'b010 : (r == 4) ? 3'b100 : 3'b000;
      check({tag, " sel"}, {29'h0, tgt_sel}, {29'h0, es});
      if (r == 3) check({tag, " R3 index"}, {22'h0, tgt_dw_addr}, 32'((a - 'h48) / 4));
      if (r == 4) check({tag, " R3 index"}, {22'h0, tgt_dw_addr}, 32'((a - 'h100) / 4));
      if (r == 1) check({tag, " R1 index"}, {22'h0, tgt_dw_addr}, 32'(a / 4));
    end
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  initial begin
    for (int i = 0; i < 16; i++) begin hdr_mem[i] = pat(i*4); cap_mem[i] = pat('h48 + i*4); end
    for (int i = 0; i < 1024; i++) ext_mem[i] = pat('h100 + i*4);
    for (int a = 0; a < 4096; a += 4) begin
      logic [31:0] p; p = pat(a < 'h48 ? a : a);
      for (int k = 0; k < 4; k++) mdl[a+k] = p[8*k +: 8];
    end
    repeat (3) @(negedge clk);
    check("R9 reset rsp_valid", {31'h0, rsp_valid}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    check("R5 ptr ssid", {24'h0, hdr_cap_ptr}, 32'h40);

    acc(0, 'h000, 4, 0, "R1 hdr dword");
    acc(0, 'h006, 2, 0, "R6 hdr half hi");
    acc(0, 'h00B, 1, 0, "R6 hdr byte3");
    acc(0, 'h034, 4, 0, "R5 ptr in header");
    acc(0, 'h040, 4, 0, "R2 id dword0");
    acc(0, 'h044, 4, 0, "R2 id dword1");
    acc(0, 'h046, 2, 0, "R2 id ssid half");
    acc(1, 'h044, 4, 32'hFFFF_FFFF, "R2 id write dropped");
    acc(0, 'h044, 4, 0, "R2 id after write");
    acc(0, 'h048, 4, 0, "R3 pcie first");
    acc(0, 'h080, 4, 0, "R3 pcie last");
    acc(0, 'h084, 4, 0, "R4 gap after pcie");
    acc(0, 'h0F2, 2, 0, "R4 gap high");
    acc(0, 'h100, 4, 0, "R3 ext first");
    acc(0, 'h1FD, 1, 0, "R3 ext byte");
    acc(1, 'h012, 1, 32'h0000_005C, "R7 hdr byte write");
    acc(0, 'h010, 4, 0, "R7 hdr byte readback");
    acc(1, 'h04E, 2, 32'h0000_9ABC, "R7 pcie half write");
    acc(0, 'h04C, 4, 0, "R7 pcie readback");
    acc(1, 'h104, 4, 32'h1234_5678, "R7 ext dword write");
    acc(0, 'h105, 2, 0, "R6 ext half mid");
    acc(0, 'h008, 3, 0, "R8 size 3");
    acc(0, 'h008, 0, 0, "R8 size 0");
    acc(1, 'h00B, 2, 32'hFFFF, "R8 half at byte3 write");
    acc(1, 'h00C, 7, 32'hFFFF, "R8 size 7 write");
    acc(0, 'h008, 4, 0, "R8 no write landed");
    acc(0, 'h00C, 4, 0, "R8 no write landed 2");
    acc(1, 'h034, 4, 32'hDEAD_BEEF, "R5 b2b ptr write");
    acc(0, 'h034, 4, 0, "R5 b2b ptr read");
    acc(0, 'h035, 1, 0, "R6 ptr dword byte1");

    cfg_ssvid = 0;
    @(negedge clk);
    check("R5 ptr pcie only", {24'h0, hdr_cap_ptr}, 32'h48);
    acc(0, 'h040, 4, 0, "R4 id off read");
    acc(1, 'h040, 4, 32'h1, "R4 id off write");
    acc(0, 'h034, 1, 0, "R5 ptr byte pcie");

    cfg_pcie_mode = 0;
    @(negedge clk);
    check("R5 ptr none", {24'h0, hdr_cap_ptr}, 32'h0);
    acc(0, 'h048, 4, 0, "R4 pcie off read");
    acc(0, 'h100, 4, 0, "R4 ext off read");
    acc(1, 'h100, 4, 32'hA5A5_A5A5, "R4 ext off write");
    acc(0, 'h034, 4, 0, "R5 ptr zero in header");

    cfg_ssvid = 16'h0F0F; cfg_ssid = 16'h2468;
    @(negedge clk);
    acc(0, 'h040, 4, 0, "R2 id next zero");
    acc(0, 'h044, 4, 0, "R2 id dword1 new");
    cfg_pcie_mode = 1;
    @(negedge clk);
    acc(0, 'h100, 4, 0, "R4 ext unchanged");
    acc(0, 'h012, 1, 0, "R7 hdr byte kept");

    repeat (3) @(negedge clk);
    check("R9 all responses seen", 32'(q_data.size()), 32'h0);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule